// File: doc/BRIEF.md
# I2C Write-Completion Acknowledge Poller

After a host has sent a write to an I2C memory-like target, the target runs an internally timed program cycle. During that cycle it does not acknowledge its own address. This block turns that behaviour into a completion test. It sends a probe, which is a start condition followed by the target's address with the read/write bit cleared, and it looks at the acknowledge bit. A missing acknowledge means the target is still busy. In that case the block closes the bus with a stop and probes again. An acknowledge means the program cycle has finished. The block then pulses `done` and leaves the bus held, with no stop, so the caller can go straight on with its next transfer.

The block does not drive SCL or SDA. It issues byte-level commands to a separate I2C master engine and waits for one response per command. If the target still refuses after a fixed number of probes, the block issues a final stop and pulses `timeout`. It can be started right after the stop that launched the write.

Top module: `i2c_ack_poller`

## Requirements
- R1: After reset, `busy`, `done`, `timeout` and `cmd_valid` are all 0.
- R2: A one-cycle `req` while `busy` is 0 latches `tgt_addr`, raises `busy`, and makes the first command a start (`cmd_op` = 0) in the next cycle.
- R3: Each probe is a start command followed by a write-byte command (`cmd_op` = 1) whose `cmd_data` is `{address, 1'b0}`, so the read/write bit (bit 0) is always 0.
- R4: When the response to a probe's write-byte has `rsp_nack` = 0, `done` pulses for exactly one cycle, `busy` drops, and no stop command follows.
- R5: When that response has `rsp_nack` = 1 and fewer than `MAX_TRIES` probes have been sent, the next command is a stop (`cmd_op` = 2), followed by a new probe.
- R6: If the `MAX_TRIES`-th probe is not acknowledged, a stop is issued, `timeout` pulses for one cycle after that stop's response, `busy` drops, and no further commands are issued.
- R7: A `req` seen while `busy` is 1 is ignored. The poll in progress keeps its address and finishes with a single `done` or `timeout`.
- R8: A command stays presented on `cmd_valid`, `cmd_op` and `cmd_data`, unchanged, until it is accepted by `cmd_ready`.
- R9: `done` and `timeout` are never high together.
- R10: Only one command is outstanding at a time. `cmd_valid` stays low after an acceptance until `rsp_valid` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle pulse that starts polling |
| tgt_addr | input | 7 | Target address, latched on an accepted `req` |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle pulse: target acknowledged, bus still held |
| timeout | output | 1 | One-cycle pulse: retry limit reached, bus released |
| cmd_valid | output | 1 | Command presented to the byte engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 2 | 0 = start, 1 = write byte, 2 = stop |
| cmd_data | output | 8 | Byte to send on a write-byte command |
| rsp_valid | input | 1 | One-cycle pulse: the accepted command has completed |
| rsp_nack | input | 1 | With `rsp_valid` after a write byte: 1 = no acknowledge |

## Verification
The hardest situations to reach are a `req` that lands in the middle of a poll, and a run that ends exactly on the retry limit: acknowledged on the last allowed probe, or refused on it. The bench engine model holds a per-run count of probes it will refuse. That count is set directly to the limit minus one, to the limit and beyond it, and it is also drawn at random. A second `req` with a different address is pulsed a few cycles into runs that last long enough. Random accept and response delays show that commands are held steady and never overlap.

// File: rtl/i2c_ack_poller.sv
module i2c_ack_poller #(
  parameter int MAX_TRIES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [6:0] tgt_addr,
  output logic       busy,
  output logic       done,
  output logic       timeout,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [1:0] cmd_op,
  output logic [7:0] cmd_data,
  input  logic       rsp_valid,
  input  logic       rsp_nack
);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam logic [1:0] OP_START = 2'd0, OP_WRITE = 2'd1, OP_STOP = 2'd2;

  typedef enum logic [2:0] {
    IDLE, ISSUE_START, WAIT_START, ISSUE_ADDR, WAIT_ADDR, ISSUE_STOP, WAIT_STOP
  } st_t;

  st_t           st;
  logic [6:0]    addr_q;
  logic [TW-1:0] tries;
  logic          give_up, done_q, tmo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      addr_q  <= '0;
      tries   <= '0;
      give_up <= 1'b0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      case (st)
        IDLE: if (req) begin
          addr_q  <= tgt_addr;
          tries   <= '0;
          give_up <= 1'b0;
          st      <= ISSUE_START;
        end
        ISSUE_START: if (cmd_ready) st <= WAIT_START;
        WAIT_START:  if (rsp_valid) st <= ISSUE_ADDR;
        ISSUE_ADDR: if (cmd_ready) begin
          tries <= tries + 1'b1;
          st    <= WAIT_ADDR;
        end
        WAIT_ADDR: if (rsp_valid) begin
          if (!rsp_nack) begin
            done_q <= 1'b1;
            st     <= IDLE;
          end else begin
            give_up <= (tries == TW'(MAX_TRIES));
            st      <= ISSUE_STOP;
          end
        end
        ISSUE_STOP: if (cmd_ready) st <= WAIT_STOP;
        WAIT_STOP: if (rsp_valid) begin
          if (give_up) begin
            tmo_q <= 1'b1;
            st    <= IDLE;
          end else begin
            st <= ISSUE_START;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign busy      = (st != IDLE);
  assign done      = done_q;
  assign timeout   = tmo_q;
  assign cmd_valid = (st == ISSUE_START) || (st == ISSUE_ADDR) || (st == ISSUE_STOP);
  assign cmd_op    = (st == ISSUE_ADDR) ? OP_WRITE : (st == ISSUE_STOP) ? OP_STOP : OP_START;
  assign cmd_data  = {addr_q, 1'b0};

  p_req_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> (busy && cmd_valid && cmd_op == OP_START));
  p_rw_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WRITE) |-> (cmd_data[0] == 1'b0));
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !cmd_valid));
  p_tries_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TW'(MAX_TRIES));
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));
  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data)));
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));
  p_one_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);
endmodule

// File: tb/i2c_ack_poller_bench.sv
module i2c_ack_poller_bench;
  localparam int MAXT = 5;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [6:0] tgt_addr = '0;
  logic busy, done, timeout, cmd_valid, cmd_ready, rsp_valid, rsp_nack;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;

  always #2 clk = ~clk;

  i2c_ack_poller #(.MAX_TRIES(MAXT)) u_i2c_ack_poller (
    .clk(clk), .rst_n(rst_n), .req(req), .tgt_addr(tgt_addr),
    .busy(busy), .done(done), .timeout(timeout),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack));

  int n_cmp = 0, n_bad = 0;
  int nlog, wr_cnt, nack_budget, n_done, n_tmo, dly;
  logic [1:0] log_op [0:63];
  logic [7:0] log_data [0:63];
  logic outstanding, prev_wait;
  logic [1:0] last_op, prev_op;
  logic [7:0] prev_data;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_probes(input int budget);
    return (budget < MAXT) ? budget + 1 : MAXT;
  endfunction

  function automatic int exp_stops(input int budget);
    return (budget < MAXT) ? budget : MAXT;
  endfunction

  initial begin
    cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_nack = 1'b0;
    outstanding = 1'b0; prev_wait = 1'b0; last_op = 2'd0;
    prev_op = 2'd0; prev_data = '0; dly = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0; rsp_nack = 1'b0;
      if (done) n_done++;
      if (timeout) n_tmo++;
      if (rst_n) chk(!(done && timeout), "R9 done/timeout overlap", int'(done), 0);
      if (outstanding) begin
        cmd_ready = 1'b0;
        if (cmd_valid) chk(1'b0, "R10 command while outstanding", 1, 0);
        dly--;
        if (dly == 0) begin
          rsp_valid = 1'b1;
          rsp_nack = (last_op == 2'd1) && (wr_cnt <= nack_budget);
          outstanding = 1'b0;
        end
      end else begin
        if (prev_wait)
          chk(cmd_valid && cmd_op == prev_op && cmd_data == prev_data,
              "R8 command held", int'(cmd_op), int'(prev_op));
        cmd_ready = ($urandom % 4) != 0;
        if (cmd_valid && cmd_ready) begin
          if (nlog < 64) begin log_op[nlog] = cmd_op; log_data[nlog] = cmd_data; end
          nlog++;
          if (cmd_op == 2'd1) wr_cnt++;
          last_op = cmd_op;
          outstanding = 1'b1;
          dly = 1 + ($urandom % 3);
          prev_wait = 1'b0;
        end else begin
          prev_wait = cmd_valid;
          prev_op = cmd_op;
          prev_data = cmd_data;
        end
      end
    end
  end

  task automatic run_poll(input logic [6:0] a, input int budget, input logic stray);
    int idx, probes, stops, guard;
    nlog = 0; wr_cnt = 0; n_done = 0; n_tmo = 0; nack_budget = budget;
    @(negedge clk);
    req = 1'b1; tgt_addr = a;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R2 busy after req", int'(busy), 1);
    if (stray) begin
      repeat (2) @(negedge clk);
      req = 1'b1; tgt_addr = a ^ 7'h55;
      @(negedge clk);
      req = 1'b0;
    end
    guard = 0;
    while (n_done == 0 && n_tmo == 0 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    repeat (12) @(negedge clk);
    probes = exp_probes(budget);
    stops = exp_stops(budget);
    chk(nlog == 2 * probes + stops, "R5 command count", nlog, 2 * probes + stops);
    idx = 0;
    for (int p = 0; p < probes; p++) begin
      if (idx < nlog && idx < 64) chk(log_op[idx] == 2'd0, "R2 start first in probe", int'(log_op[idx]), 0);
      idx++;
      if (idx < nlog && idx < 64) begin
        chk(log_op[idx] == 2'd1, "R3 write after start", int'(log_op[idx]), 1);
        chk(log_data[idx] == {a, 1'b0}, "R3 R7 control byte", int'(log_data[idx]), int'({a, 1'b0}));
      end
      idx++;
      if (p < stops) begin
        if (idx < nlog && idx < 64) chk(log_op[idx] == 2'd2, "R5 R6 stop after nack", int'(log_op[idx]), 2);
        idx++;
      end
    end
    if (budget < MAXT) begin
      chk(n_done == 1, "R4 R7 single done", n_done, 1);
      chk(n_tmo == 0, "R4 no timeout", n_tmo, 0);
    end else begin
      chk(n_tmo == 1, "R6 R7 single timeout", n_tmo, 1);
      chk(n_done == 0, "R6 no done", n_done, 0);
    end
    chk(busy == 1'b0, "R4 R6 idle at end", int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    nlog = 0; wr_cnt = 0; nack_budget = 0; n_done = 0; n_tmo = 0;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !timeout && !cmd_valid, "R1 reset outputs",
        int'({busy, done, timeout, cmd_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !cmd_valid, "R1 idle after reset", int'({busy, cmd_valid}), 0);
    run_poll(7'h50, 0, 1'b0);
    run_poll(7'h2A, MAXT - 1, 1'b1);
    run_poll(7'h7F, MAXT, 1'b1);
    run_poll(7'h01, MAXT + 4, 1'b0);
    run_poll(7'h00, 1, 1'b1);
    for (int k = 0; k < 20; k++) begin
      int b;
      b = $urandom % 8;
      run_poll(7'($urandom), b, (b >= 1) && ($urandom % 2 == 1));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule